// File: doc/BRIEF.md
# Smart Card Character Transceiver with Automatic Retransmission

This block moves 8-bit characters over a single open-drain I/O line shared with a smart card. Only one side talks at a time. A character on the line is a low start bit, eight data bits sent least significant bit first, and an even parity bit. After the parity bit comes a short slot in which whoever received the character may pull the line low to reject it.

On receive, a parity failure is reported in-band. The block pulls the line low during the rejection slot so that the card sends the character again. The failed character never reaches the receive register. On transmit, the block looks for such a rejection pulse from the card. When it sees one, it raises a flag and sends the same character again after a fixed back-off. The host side works like a register file: a transmit data write strobe, a receive data register with a read strobe, sticky status flags with clear strobes, two interrupt enables and three interrupt outputs. The length of one elementary time unit (etu) is set in clock cycles at a port.

Top module: `sc_char_xcvr`

States of the transmit machine:
- TX_IDLE goes to TX_BITS when a character is pending and the receiver is idle.
- TX_BITS goes to TX_CHECK after the parity bit.
- TX_CHECK goes to TX_BACKOFF if the line is low at its end, otherwise to TX_GAP.
- TX_BACKOFF goes to TX_BITS to resend the same character.
- TX_GAP goes to TX_IDLE.

States of the receive machine:
- RX_IDLE goes to RX_START on a falling line edge.
- RX_START goes to RX_BITS if the line is still low at half an etu, otherwise back to RX_IDLE.
- RX_BITS goes to RX_SLOT after sampling parity.
- RX_SLOT goes to RX_DRIVE on a parity failure, otherwise to RX_TAIL.
- RX_DRIVE and RX_TAIL both go to RX_IDLE.

## Requirements
- R1: A transmitted frame holds the line low for the start bit, then sends data bits 0 to 7 in that order and a parity bit making the count of ones among data plus parity even. Each bit lasts exactly `etu_len` clock cycles, and the line is released at every other time the transmitter owns it.
- R2: A received frame whose parity is odd sets `par_err`, and `irq_err` is high while `par_err` and `rx_ie` are both 1.
- R3: A received frame with a parity failure leaves `rx_full` at 0 and `rx_rdata` unchanged.
- R4: A received frame with correct parity loads `rx_rdata`, sets `rx_full`, and leaves `par_err` clear. `irq_rx` follows `rx_full` while `rx_ie` is 1.
- R5: After a parity failure the receiver pulls the line low for exactly `etu_len + etu_len/2` cycles, starting about half an etu after the parity bit ends and before one etu after it. After a good frame it never pulls the line during the slot.
- R6: If the line is low one etu after the end of a transmitted parity bit, `err_sig` is set, and `irq_err` is raised when `rx_ie` is 1.
- R7: After a rejection, the same character starts again exactly 3 etu after the end of its parity bit. `tx_empty` stays 0 until a frame goes unrejected, then returns to 1. `irq_tx` follows `tx_empty` while `tx_ie` is 1.
- R8: A pulse on `rx_rd` clears `rx_full`.
- R9: A pulse on `par_err_clr` clears `par_err`, and a pulse on `err_sig_clr` clears `err_sig`.
- R10: After reset the line is released, `tx_empty` is 1, and `rx_full`, `par_err`, `err_sig` and all interrupts are 0.
- R11: A `tx_load` while `tx_empty` is 0 is ignored: no extra frame is ever sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_len | input | ETU_W | Clock cycles per elementary time unit (at least 8) |
| tx_load | input | 1 | Write strobe for the transmit character |
| tx_wdata | input | DATA_W | Transmit character |
| tx_empty | output | 1 | Transmit register free (last character accepted) |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_rdata | output | DATA_W | Last correctly received character |
| rx_full | output | 1 | Receive register holds an unread character |
| par_err | output | 1 | Sticky receive parity failure flag |
| par_err_clr | input | 1 | Clears `par_err` |
| err_sig | output | 1 | Sticky flag: far end rejected a transmitted frame |
| err_sig_clr | input | 1 | Clears `err_sig` |
| rx_ie | input | 1 | Enables `irq_rx` and `irq_err` |
| tx_ie | input | 1 | Enables `irq_tx` |
| irq_err | output | 1 | Error interrupt |
| irq_rx | output | 1 | Receive data interrupt |
| irq_tx | output | 1 | Transmit register empty interrupt |
| io_in | input | 1 | Sensed level of the shared line |
| io_oe | output | 1 | 1 pulls the line low, 0 releases it |

## Verification
The bench builds the block with `ETU_W = 6` and runs two etu lengths, 16 and 11 cycles. The odd value makes the half-etu points round down, which puts the mid-bit sampling, the rejection window and the 1.5-etu pulse length under a case where halves are not exact. The short etu keeps each frame near two hundred cycles, so every run covers all of the following within a small cycle budget:
- rejected and accepted frames in both directions;
- the exact 3-etu resend gap;
- the pulse length.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [2:0] {
        TX_IDLE    = 3'd0,
        TX_BITS    = 3'd1,
        TX_CHECK   = 3'd2,
        TX_BACKOFF = 3'd3,
        TX_GAP     = 3'd4
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_BITS  = 3'd2,
        RX_SLOT  = 3'd3,
        RX_DRIVE = 3'd4,
        RX_TAIL  = 3'd5
    } rx_state_t;

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= 1'b1;
                    else        pipe[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= 1'b1;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sc_tx_fsm.sv
module sc_tx_fsm
    import sc_pkg::*;
#(
    parameter int ETU_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ETU_W-1:0]  etu_len,
    input  logic              start,
    input  logic [DATA_W-1:0] char_in,
    input  logic              line_s,
    output logic              busy,
    output logic              drive_low,
    output logic              ok_evt,
    output logic              err_evt
);
    localparam int CNT_W = ETU_W + 2;
    localparam int FRM   = DATA_W + 2;
    localparam int IDX_W = $clog2(FRM);

    tx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [FRM-1:0]    shreg;
    logic [DATA_W-1:0] held;

    logic [CNT_W-1:0]  etu_m1;
    logic [CNT_W-1:0]  two_m1;
    logic              etu_end;
    logic              two_end;

    assign etu_m1  = CNT_W'(etu_len) - CNT_W'(1);
    assign two_m1  = (CNT_W'(etu_len) << 1) - CNT_W'(1);
    assign etu_end = (cnt == etu_m1);
    assign two_end = (cnt == two_m1);

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '1;
            held  <= '0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        held  <= char_in;
                        shreg <= {^char_in, char_in, 1'b0};
                        idx   <= '0;
                        state <= TX_BITS;
                    end
                end
                TX_BITS: begin
                    if (etu_end) begin
                        cnt   <= '0;
                        shreg <= {1'b1, shreg[FRM-1:1]};
                        if (idx == IDX_W'(FRM - 1)) state <= TX_CHECK;
                        else                        idx   <= idx + IDX_W'(1);
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                TX_CHECK: begin
                    if (etu_end) begin
                        cnt   <= '0;
                        state <= line_s ? TX_GAP : TX_BACKOFF;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                TX_BACKOFF: begin
                    if (two_end) begin
                        cnt   <= '0;
                        idx   <= '0;
                        shreg <= {^held, held, 1'b0};
                        state <= TX_BITS;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                TX_GAP: begin
                    if (two_end) begin
                        cnt   <= '0;
                        state <= TX_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != TX_IDLE);
        drive_low = (state == TX_BITS) && !shreg[0];
        ok_evt    = (state == TX_CHECK) && etu_end && line_s;
        err_evt   = (state == TX_CHECK) && etu_end && !line_s;
    end
endmodule

// File: rtl/sc_rx_fsm.sv
module sc_rx_fsm
    import sc_pkg::*;
#(
    parameter int ETU_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ETU_W-1:0]  etu_len,
    input  logic              enable,
    input  logic              line_s,
    output logic              busy,
    output logic              drive_low,
    output logic              good_evt,
    output logic              bad_evt,
    output logic [DATA_W-1:0] char_out
);
    localparam int CNT_W = ETU_W + 2;
    localparam int IDX_W = $clog2(DATA_W + 1);

    rx_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [DATA_W:0]  shreg;
    logic             frame_bad;
    logic             line_q;

    logic [CNT_W-1:0] etu_m1;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] slot_last;
    logic             etu_end;
    logic             par_pt;
    logic             par_odd;

    assign etu_m1    = CNT_W'(etu_len) - CNT_W'(1);
    assign half_m1   = CNT_W'(etu_len >> 1) - CNT_W'(1);
    assign slot_last = etu_m1 + CNT_W'(etu_len >> 1);
    assign etu_end   = (cnt == etu_m1);
    assign par_pt    = (state == RX_BITS) && etu_end && (idx == IDX_W'(DATA_W));
    assign par_odd   = ^{line_s, shreg[DATA_W:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_s;
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            frame_bad <= 1'b0;
        end else begin
            unique case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    if (enable && line_q && !line_s) state <= RX_START;
                end
                RX_START: begin
                    if (cnt == half_m1) begin
                        cnt   <= '0;
                        idx   <= '0;
                        state <= line_s ? RX_IDLE : RX_BITS;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                RX_BITS: begin
                    if (etu_end) begin
                        cnt   <= '0;
                        shreg <= {line_s, shreg[DATA_W:1]};
                        if (idx == IDX_W'(DATA_W)) begin
                            frame_bad <= par_odd;
                            state     <= RX_SLOT;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                RX_SLOT: begin
                    if (etu_end) begin
                        cnt   <= '0;
                        state <= frame_bad ? RX_DRIVE : RX_TAIL;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                RX_DRIVE, RX_TAIL: begin
                    if (cnt == slot_last) begin
                        cnt   <= '0;
                        state <= RX_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != RX_IDLE);
        drive_low = (state == RX_DRIVE);
        good_evt  = par_pt && !par_odd;
        bad_evt   = par_pt && par_odd;
        char_out  = shreg[DATA_W:1];
    end
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr #(
    parameter int ETU_W       = 12,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ETU_W-1:0]  etu_len,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic              tx_empty,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              rx_full,
    output logic              par_err,
    input  logic              par_err_clr,
    output logic              err_sig,
    input  logic              err_sig_clr,
    input  logic              rx_ie,
    input  logic              tx_ie,
    output logic              irq_err,
    output logic              irq_rx,
    output logic              irq_tx,
    input  logic              io_in,
    output logic              io_oe
);
    logic              line_s;
    logic              tx_busy, tx_oe, tx_ok, tx_err, tx_start;
    logic              rx_busy, rx_oe, rx_good, rx_bad;
    logic [DATA_W-1:0] rx_char;
    logic [DATA_W-1:0] tx_hold;
    logic              tx_pend;
    logic              load_ok;

    sc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (io_in),
        .dout (line_s)
    );

    assign load_ok  = tx_load && tx_empty;
    assign tx_start = tx_pend && !tx_busy && !rx_busy;

    sc_tx_fsm #(.ETU_W(ETU_W), .DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .etu_len  (etu_len),
        .start    (tx_start),
        .char_in  (tx_hold),
        .line_s   (line_s),
        .busy     (tx_busy),
        .drive_low(tx_oe),
        .ok_evt   (tx_ok),
        .err_evt  (tx_err)
    );

    sc_rx_fsm #(.ETU_W(ETU_W), .DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .etu_len  (etu_len),
        .enable   (!tx_busy && !tx_pend),
        .line_s   (line_s),
        .busy     (rx_busy),
        .drive_low(rx_oe),
        .good_evt (rx_good),
        .bad_evt  (rx_bad),
        .char_out (rx_char)
    );

    // host-side registers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold  <= '0;
            tx_pend  <= 1'b0;
            tx_empty <= 1'b1;
            rx_rdata <= '0;
            rx_full  <= 1'b0;
            par_err  <= 1'b0;
            err_sig  <= 1'b0;
        end else begin
            if (load_ok) tx_hold <= tx_wdata;

            if (load_ok)       tx_pend <= 1'b1;
            else if (tx_start) tx_pend <= 1'b0;

            if (tx_ok)        tx_empty <= 1'b1;
            else if (load_ok) tx_empty <= 1'b0;

            if (rx_good) rx_rdata <= rx_char;

            if (rx_good)    rx_full <= 1'b1;
            else if (rx_rd) rx_full <= 1'b0;

            if (rx_bad)           par_err <= 1'b1;
            else if (par_err_clr) par_err <= 1'b0;

            if (tx_err)           err_sig <= 1'b1;
            else if (err_sig_clr) err_sig <= 1'b0;
        end
    end

    always_comb begin
        io_oe   = tx_oe | rx_oe;
        irq_err = rx_ie & (par_err | err_sig);
        irq_rx  = rx_ie & rx_full;
        irq_tx  = tx_ie & tx_empty;
    end
endmodule

// File: rtl/sc_char_xcvr_chk.sv
module sc_char_xcvr_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_rd,
    input logic rx_full,
    input logic par_err,
    input logic par_err_clr,
    input logic err_sig,
    input logic tx_empty,
    input logic tx_oe,
    input logic rx_oe,
    input logic rx_good,
    input logic rx_bad,
    input logic tx_err
);
    AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_oe && rx_oe)); // R1

    AST_BAD_SETS_PER: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bad |=> par_err); // R2

    AST_BAD_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bad && !rx_full) |=> !rx_full); // R3

    AST_GOOD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_good |=> rx_full); // R4

    AST_GOOD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        rx_good |=> !rx_oe); // R5

    AST_ERR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |=> err_sig); // R6

    AST_ERR_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |=> !tx_empty); // R7

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_good) |=> !rx_full); // R8

    AST_PER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_clr && !rx_bad) |=> !par_err); // R9
endmodule

bind sc_char_xcvr sc_char_xcvr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_rd      (rx_rd),
    .rx_full    (rx_full),
    .par_err    (par_err),
    .par_err_clr(par_err_clr),
    .err_sig    (err_sig),
    .tx_empty   (tx_empty),
    .tx_oe      (tx_oe),
    .rx_oe      (rx_oe),
    .rx_good    (rx_good),
    .rx_bad     (rx_bad),
    .tx_err     (tx_err)
);

// File: tb/sc_char_xcvr_tb.sv
module sc_char_xcvr_tb;
    localparam int ETU_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ETU_W-1:0] etu_len = 6'd16;
    logic tx_load = 0, rx_rd = 0, par_err_clr = 0, err_sig_clr = 0;
    logic rx_ie = 1'b1, tx_ie = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic tx_empty, rx_full, par_err, err_sig, irq_err, irq_rx, irq_tx, io_oe;
    logic [7:0] rx_rdata;
    logic card_drv = 1'b0;
    logic line;

    assign line = ~(io_oe | card_drv);

    always #10 clk = ~clk;

    sc_char_xcvr #(.ETU_W(ETU_W), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .etu_len(etu_len),
        .tx_load(tx_load), .tx_wdata(tx_wdata), .tx_empty(tx_empty),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_full(rx_full),
        .par_err(par_err), .par_err_clr(par_err_clr),
        .err_sig(err_sig), .err_sig_clr(err_sig_clr),
        .rx_ie(rx_ie), .tx_ie(tx_ie),
        .irq_err(irq_err), .irq_rx(irq_rx), .irq_tx(irq_tx),
        .io_in(line), .io_oe(io_oe)
    );

    int checks = 0;
    int errors = 0;
    int E = 16;
    int inj_err = 0;
    int frames_seen = 0;
    bit tx_mon_en = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // driver: host writes a character, expected frame is queued
    task automatic host_send(input logic [7:0] b);
        @(negedge clk);
        tx_q.push_back(b);
        tx_wdata = b;
        tx_load  = 1'b1;
        @(negedge clk);
        tx_load  = 1'b0;
    endtask

    task automatic host_poke(input logic [7:0] b);
        @(negedge clk);
        tx_wdata = b;
        tx_load  = 1'b1;
        @(negedge clk);
        tx_load  = 1'b0;
    endtask

    task automatic wait_tx_done();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (tx_empty && tx_q.size() == 0) break;
        end
        repeat (3 * E) @(negedge clk);
    endtask

    // card transmits a frame; measures the block's reply in the slot
    int oe_cnt;
    int oe_first;
    task automatic card_send(input logic [7:0] b, input bit bad);
        logic [9:0] bits;
        bits = {(^b) ^ bad, b, 1'b0};
        if (!bad) rx_q.push_back(b);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            card_drv = ~bits[k];
            repeat (E - 1) @(negedge clk);
        end
        @(negedge clk);
        card_drv = 1'b0;
        oe_cnt   = 0;
        oe_first = -1;
        for (int t = 0; t < 3 * E; t++) begin
            if (io_oe) begin
                oe_cnt++;
                if (oe_first < 0) oe_first = t;
            end
            @(negedge clk);
        end
        repeat (E) @(negedge clk);
    endtask

    // monitor: frames the block transmits
    int ncnt = 0;
    always @(negedge clk) ncnt++;

    initial begin : tx_monitor
        logic prev;
        logic [9:0] got;
        int t_end;
        bit gap_pending;
        prev = 1'b1;
        gap_pending = 0;
        t_end = 0;
        forever begin
            @(negedge clk);
            if (tx_mon_en && prev === 1'b1 && line === 1'b0) begin
                frames_seen++;
                if (gap_pending) begin
                    chk(ncnt - t_end == 3 * E, "R7 resend gap", ncnt - t_end, 3 * E);
                    gap_pending = 0;
                end
                repeat (E / 2) @(negedge clk);
                got[0] = line;
                for (int k = 1; k < 10; k++) begin
                    repeat (E) @(negedge clk);
                    got[k] = line;
                end
                repeat (E - E / 2) @(negedge clk);
                t_end = ncnt;
                chk(got[0] == 1'b0, "R1 start bit", got[0], 0);
                chk(^got[9:1] == 1'b0, "R1 even parity", got[9], ^got[8:1]);
                if (tx_q.size() == 0) begin
                    chk(0, "R11 unexpected frame", got[8:1], 0);
                end else begin
                    logic [7:0] exp;
                    exp = tx_q.pop_front();
                    chk(got[8:1] == exp, "R1 data", got[8:1], exp);
                    if (inj_err > 0) begin
                        inj_err--;
                        tx_q.push_front(exp);
                        repeat (E / 2) @(negedge clk);
                        card_drv = 1'b1;
                        repeat (E + E / 2) @(negedge clk);
                        card_drv = 1'b0;
                        gap_pending = 1;
                    end
                end
            end
            prev = line;
        end
    end

    // monitor: characters the block receives
    initial begin : rx_monitor
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rx_full && !prev) begin
                if (rx_q.size() == 0) begin
                    chk(0, "R3 unexpected rx_full", rx_rdata, 0);
                end else begin
                    logic [7:0] exp;
                    exp = rx_q.pop_front();
                    chk(rx_rdata == exp, "R4 rx data", rx_rdata, exp);
                    chk(irq_rx == rx_ie, "R4 irq_rx", irq_rx, rx_ie);
                    chk(par_err == 1'b0, "R4 par_err clear", par_err, 0);
                end
                rx_rd = 1'b1;
                @(negedge clk);
                rx_rd = 1'b0;
                chk(rx_full == 1'b0, "R8 read clears", rx_full, 0);
            end
            prev = rx_full;
        end
    end

    task automatic run_round(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        int oe_seen;
        // clean transmit
        tx_mon_en = 1;
        host_send(a);
        wait_tx_done();
        chk(tx_empty == 1'b1, "R7 tx_empty after ok", tx_empty, 1);
        tx_ie = 1'b1;
        @(negedge clk);
        chk(irq_tx == 1'b1, "R7 irq_tx", irq_tx, 1);
        tx_ie = 1'b0;
        chk(err_sig == 1'b0, "R6 no err_sig", err_sig, 0);
        // rejected then resent
        inj_err = 1;
        host_send(b);
        wait_tx_done();
        chk(inj_err == 0, "R7 rejection consumed", inj_err, 0);
        chk(err_sig == 1'b1, "R6 err_sig set", err_sig, 1);
        chk(irq_err == 1'b1, "R6 irq_err", irq_err, 1);
        chk(tx_empty == 1'b1, "R7 tx_empty after resend", tx_empty, 1);
        @(negedge clk);
        err_sig_clr = 1'b1;
        @(negedge clk);
        err_sig_clr = 1'b0;
        chk(err_sig == 1'b0, "R9 err_sig cleared", err_sig, 0);
        // ignored second load
        frames_seen = 0;
        host_send(c);
        host_poke(8'hFF);
        wait_tx_done();
        oe_seen = 0;
        for (int i = 0; i < 10 * E; i++) begin
            @(negedge clk);
            if (io_oe) oe_seen++;
        end
        chk(frames_seen == 1, "R11 one frame only", frames_seen, 1);
        chk(oe_seen == 0, "R11 line idle", oe_seen, 0);
        tx_mon_en = 0;
        // receive good
        card_send(c ^ 8'h5A, 1'b0);
        chk(oe_cnt == 0, "R5 released on good", oe_cnt, 0);
        // receive bad
        card_send(b ^ 8'h33, 1'b1);
        chk(oe_cnt == E + E / 2, "R5 error pulse length", oe_cnt, E + E / 2);
        chk(oe_first >= 1 && oe_first < E, "R5 error pulse start", oe_first, E / 2);
        chk(par_err == 1'b1, "R2 par_err set", par_err, 1);
        chk(irq_err == 1'b1, "R2 irq_err", irq_err, 1);
        chk(rx_full == 1'b0, "R3 rx_full stays 0", rx_full, 0);
        chk(rx_rdata == (c ^ 8'h5A), "R3 rx_data kept", rx_rdata, c ^ 8'h5A);
        rx_ie = 1'b0;
        @(negedge clk);
        chk(irq_err == 1'b0, "R2 irq_err masked", irq_err, 0);
        rx_ie = 1'b1;
        par_err_clr = 1'b1;
        @(negedge clk);
        par_err_clr = 1'b0;
        chk(par_err == 1'b0, "R9 par_err cleared", par_err, 0);
        // resent by card, good
        card_send(b ^ 8'h33, 1'b0);
        chk(oe_cnt == 0, "R5 released on resend", oe_cnt, 0);
        chk(rx_q.size() == 0, "R4 all received", rx_q.size(), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(io_oe == 1'b0, "R10 line released", io_oe, 0);
        chk(tx_empty == 1'b1, "R10 tx_empty", tx_empty, 1);
        chk(rx_full == 1'b0, "R10 rx_full", rx_full, 0);
        chk(par_err == 1'b0 && err_sig == 1'b0, "R10 flags", {par_err, err_sig}, 0);
        chk({irq_err, irq_rx, irq_tx} == 3'b000, "R10 irqs", {irq_err, irq_rx, irq_tx}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        E = 16;
        etu_len = 6'd16;
        run_round(8'hA5, 8'h3C, 8'h81);

        E = 11;
        etu_len = 6'd11;
        repeat (4) @(negedge clk);
        run_round(8'h01, 8'hE7, 8'h7F);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule